// File: doc/BRIEF.md
# Host Port Mailbox and Data Select

This block sits between an 8-bit host port and the device's own logic. Two host select lines decide what the device returns on the data lines. The choices are the current sample byte of channel A, the current sample byte of channel B, a one-byte mailbox, or a fixed identification byte. The data lines are driven only while the host has released the bus. After any change of the select lines, the block waits a configurable number of cycles before it presents the newly selected source. This stands in for the settling time of the real data path.

The mailbox is a single shared byte used for half-duplex exchange between the host and a local controller. Whichever side writes last sees zero from then on. The other side sees the written byte until it writes a reply. A reading of zero therefore means "nothing new yet", and a zero byte is never carried: writes of zero are dropped. The host writes by selecting the mailbox, driving the byte and raising its strobe. The local controller writes with a one-cycle enable. If both write in the same cycle, the local byte is stored first and the host byte lands one cycle later.

Top module: `hostport_mbx_mux`

## Requirements
- R1: With select code {hostSelMbx, hostSelAlt} = 00 the output carries chanAData, 01 carries chanBData, 10 carries the host's view of the mailbox, and 11 carries the constant identification byte 0x55.
- R2: After the select code changes, devDataOut keeps its previous value through SETTLE_CYC+1 rising edges and shows the new source after edge SETTLE_CYC+2, counting the first edge that samples the new code as edge 1.
- R3: devDataOe equals hostReadEn: the device drives the data lines only while the host has released them.
- R4: A host write happens on the first edge that samples hostStrobe high after it was low, with select code 10, hostReadEn low and nonzero hostDataIn. locRdData shows the byte right after that edge.
- R5: After a host write the host's mailbox view reads 0 until the local side writes. After a local write of byte v, the host view reads v, which reaches devDataOut one edge later while select 10 is settled.
- R6: After a local write (locWrEn high with nonzero locWrData at an edge), locRdData reads 0 until the host writes.
- R7: A write of zero from either side changes nothing: neither view changes.
- R8: When a host write and a local write fall on the same edge, the local byte is stored on that edge and the host byte on the next edge. After that second edge locRdData shows the host byte and the host view reads 0.
- R9: A host strobe has no effect when the select code is not 10 or hostReadEn is high. A strobe held high writes only once.
- R10: During and right after reset, devDataOut and locRdData are 0 and the mailbox is empty in both views.
- R11: Once the select code has settled, devDataOut follows changes of the selected source one edge later. This includes a mailbox view that moves from 0 to a valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSelMbx | input | 1 | Host select line, high bit of the select code |
| hostSelAlt | input | 1 | Host select line, low bit of the select code |
| hostStrobe | input | 1 | Host write strobe, active high, edge detected |
| hostReadEn | input | 1 | High when the host has released the data lines |
| hostDataIn | input | DATA_W | Byte driven by the host |
| devDataOut | output | DATA_W | Byte presented to the host |
| devDataOe | output | 1 | Output enable for devDataOut |
| chanAData | input | DATA_W | Current channel A sample |
| chanBData | input | DATA_W | Current channel B sample |
| locWrEn | input | 1 | Local mailbox write enable |
| locWrData | input | DATA_W | Local mailbox write byte |
| locRdData | output | DATA_W | Local view of the mailbox, 0 means no reply |

## Verification
Every value 0 to 255 is swept through channel A and channel B while they are selected. This separates the two channel paths and shows the one-edge follow latency, while the identification code stays fixed whatever the channels carry. The mailbox is swept with every nonzero local byte, each answered by a derived host byte. Each exchange checks that the writer's own view blanks and the reader's view fills, so swapped or missing blanking shows at once. Separate patterns cover zero writes, strobes with the wrong select or bus direction, a held strobe, a same-edge collision where the order of the two stored bytes is visible, and a select change timed edge by edge against the settle count.

// File: rtl/hostport_mbx_pkg.sv
package hostport_mbx_pkg;

  // Select code formed as {hostSelMbx, hostSelAlt}
  typedef enum logic [1:0] {
    SRC_CHA = 2'b00,
    SRC_CHB = 2'b01,
    SRC_MBX = 2'b10,
    SRC_ID  = 2'b11
  } srcSel_t;

  // Side that wrote the mailbox last
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_HOST  = 2'b01,
    OWN_LOCAL = 2'b10
  } mbxOwner_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic locWr;       // store local byte
    logic hostWrNow;   // store host byte from the bus
    logic hostWrPend;  // store the deferred host byte
    logic pendCapture; // park host byte behind a local write
    logic outLoad;     // refresh the output register
  } mbxCtl_t;

endpackage

// File: rtl/hostport_mbx_settle.sv
module hostport_mbx_settle #(
  parameter int SETTLE_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] sel,
  output logic       settled
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYC);

  logic [1:0]       selPrev;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selPrev <= '0;
      waitCnt <= '0;
    end else begin
      selPrev <= sel;
      if (sel != selPrev)
        waitCnt <= '0;
      else if (waitCnt != CNT_MAX)
        waitCnt <= waitCnt + 1'b1;
    end
  end

  assign settled = (sel == selPrev) && (waitCnt == CNT_MAX);

endmodule

// File: rtl/hostport_mbx_ctrl.sv
module hostport_mbx_ctrl
  import hostport_mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        sel,
  input  logic              hostStrobe,
  input  logic              hostReadEn,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic              locWrEn,
  input  logic [DATA_W-1:0] locWrData,
  input  logic              settled,
  output mbxCtl_t           ctl
);
  logic strobePrev;
  logic pendHost;
  logic pendNext;
  logic strobeRise;
  logic hostReq;
  logic locReq;

  always_comb begin
    strobeRise = hostStrobe && !strobePrev;
    hostReq    = strobeRise && (sel == SRC_MBX) && !hostReadEn && (hostDataIn != '0);
    locReq     = locWrEn && (locWrData != '0);
    ctl        = '0;
    ctl.outLoad = settled;
    pendNext   = pendHost;
    if (locReq) begin
      ctl.locWr = 1'b1;
      if (hostReq) begin
        ctl.pendCapture = 1'b1;
        pendNext        = 1'b1;
      end
    end else if (hostReq) begin
      ctl.hostWrNow = 1'b1;
      pendNext      = 1'b0;
    end else if (pendHost) begin
      ctl.hostWrPend = 1'b1;
      pendNext       = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      pendHost   <= 1'b0;
    end else begin
      strobePrev <= hostStrobe;
      pendHost   <= pendNext;
    end
  end

endmodule

// File: rtl/hostport_mbx_dp.sv
module hostport_mbx_dp
  import hostport_mbx_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  ID_CODE = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxCtl_t           ctl,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] chanAData,
  input  logic [DATA_W-1:0] chanBData,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] locWrData,
  output logic [DATA_W-1:0] devDataOut,
  output logic [DATA_W-1:0] locRdData,
  output logic [DATA_W-1:0] hostView
);
  logic [DATA_W-1:0] mbxByte;
  logic [DATA_W-1:0] pendByte;
  logic [DATA_W-1:0] outReg;
  logic [DATA_W-1:0] srcVal;
  mbxOwner_t         owner;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mbxByte  <= '0;
      pendByte <= '0;
      outReg   <= '0;
      owner    <= OWN_NONE;
    end else begin
      if (ctl.pendCapture) pendByte <= hostDataIn;
      if (ctl.locWr) begin
        mbxByte <= locWrData;
        owner   <= OWN_LOCAL;
      end else if (ctl.hostWrNow) begin
        mbxByte <= hostDataIn;
        owner   <= OWN_HOST;
      end else if (ctl.hostWrPend) begin
        mbxByte <= pendByte;
        owner   <= OWN_HOST;
      end
      if (ctl.outLoad) outReg <= srcVal;
    end
  end

  always_comb begin
    hostView  = (owner == OWN_HOST)  ? '0 : mbxByte;
    locRdData = (owner == OWN_LOCAL) ? '0 : mbxByte;
    unique case (srcSel_t'(sel))
      SRC_CHA: srcVal = chanAData;
      SRC_CHB: srcVal = chanBData;
      SRC_MBX: srcVal = hostView;
      default: srcVal = DATA_W'(ID_CODE);
    endcase
  end

  assign devDataOut = outReg;

endmodule

// File: rtl/hostport_mbx_mux.sv
module hostport_mbx_mux
  import hostport_mbx_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         SETTLE_CYC = 3,
  parameter logic [7:0] ID_CODE    = 8'h55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSelMbx,
  input  logic              hostSelAlt,
  input  logic              hostStrobe,
  input  logic              hostReadEn,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] devDataOut,
  output logic              devDataOe,
  input  logic [DATA_W-1:0] chanAData,
  input  logic [DATA_W-1:0] chanBData,
  input  logic              locWrEn,
  input  logic [DATA_W-1:0] locWrData,
  output logic [DATA_W-1:0] locRdData
);
  logic [1:0]        selCode;
  logic              settled;
  mbxCtl_t           ctlBus;
  logic [DATA_W-1:0] hostView;

  assign selCode   = {hostSelMbx, hostSelAlt};
  assign devDataOe = hostReadEn;

  hostport_mbx_settle #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
    .clk     (clk),
    .rstN    (rstN),
    .sel     (selCode),
    .settled (settled)
  );

  hostport_mbx_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sel        (selCode),
    .hostStrobe (hostStrobe),
    .hostReadEn (hostReadEn),
    .hostDataIn (hostDataIn),
    .locWrEn    (locWrEn),
    .locWrData  (locWrData),
    .settled    (settled),
    .ctl        (ctlBus)
  );

  hostport_mbx_dp #(.DATA_W(DATA_W), .ID_CODE(ID_CODE)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctlBus),
    .sel        (selCode),
    .chanAData  (chanAData),
    .chanBData  (chanBData),
    .hostDataIn (hostDataIn),
    .locWrData  (locWrData),
    .devDataOut (devDataOut),
    .locRdData  (locRdData),
    .hostView   (hostView)
  );

endmodule

// File: rtl/hostport_mbx_checker.sv
module hostport_mbx_checker
  import hostport_mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        selCode,
  input logic              hostStrobe,
  input logic              locWrEn,
  input logic [DATA_W-1:0] locWrData,
  input logic [DATA_W-1:0] locRdData,
  input logic [DATA_W-1:0] hostView,
  input logic [DATA_W-1:0] devDataOut,
  input mbxCtl_t           ctl
);

  a_r6_local_blank: assert property (@(posedge clk) disable iff (!rstN)
    (locWrEn && locWrData != '0) |=> (locRdData == '0));

  a_r5_host_blank: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hostWrNow || ctl.hostWrPend) |=> (hostView == '0));

  a_r7_zero_write: assert property (@(posedge clk) disable iff (!rstN)
    (locWrEn && locWrData == '0 && !ctl.hostWrNow && !ctl.hostWrPend) |=> $stable(locRdData));

  a_r8_local_first: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pendCapture |-> (ctl.locWr && !ctl.hostWrNow));

  a_r8_pend_lands: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pendCapture |=> (ctl.hostWrPend || ctl.locWr || ctl.hostWrNow));

  a_r8_one_writer: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.locWr, ctl.hostWrNow, ctl.hostWrPend}));

  a_r2_hold_on_change: assert property (@(posedge clk) disable iff (!rstN)
    (selCode != $past(selCode)) |=> $stable(devDataOut));

  a_r9_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    (hostStrobe && $past(hostStrobe)) |-> !ctl.hostWrNow);

endmodule

bind hostport_mbx_mux hostport_mbx_checker #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .selCode    (selCode),
  .hostStrobe (hostStrobe),
  .locWrEn    (locWrEn),
  .locWrData  (locWrData),
  .locRdData  (locRdData),
  .hostView   (hostView),
  .devDataOut (devDataOut),
  .ctl        (ctlBus)
);

// File: tb/hostport_mbx_mux_tb.sv
module hostport_mbx_mux_tb_top;
  localparam int CLK_P  = 10;
  localparam int SETTLE = 3;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hostSelMbx, hostSelAlt, hostStrobe, hostReadEn;
  logic [7:0] hostDataIn, devDataOut, chanAData, chanBData, locWrData, locRdData;
  logic       devDataOe, locWrEn;

  int nRun  = 0;
  int nFail = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hostport_mbx_mux #(.DATA_W(8), .SETTLE_CYC(SETTLE), .ID_CODE(8'h55)) dut_i (
    .clk(clk), .rstN(rstN), .hostSelMbx(hostSelMbx), .hostSelAlt(hostSelAlt),
    .hostStrobe(hostStrobe), .hostReadEn(hostReadEn), .hostDataIn(hostDataIn),
    .devDataOut(devDataOut), .devDataOe(devDataOe), .chanAData(chanAData),
    .chanBData(chanBData), .locWrEn(locWrEn), .locWrData(locWrData), .locRdData(locRdData)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic selectSrc(input logic [1:0] code);
    {hostSelMbx, hostSelAlt} = code;
    step(SETTLE + 2);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; hostSelMbx = 1'b0; hostSelAlt = 1'b0; hostStrobe = 1'b0;
    hostReadEn = 1'b1; hostDataIn = 8'h00; chanAData = 8'hA1; chanBData = 8'hB2;
    locWrEn = 1'b0; locWrData = 8'h00;
    step(3);
    chk("R10 out in reset", devDataOut, 8'h00);
    chk("R10 local view in reset", locRdData, 8'h00);
    rstN = 1'b1;
    step(1);
    chk("R10 out after reset", devDataOut, 8'h00);
    chk("R10 local view after reset", locRdData, 8'h00);
    step(SETTLE + 1);
    chk("R1 chan A", devDataOut, 8'hA1);

    // R2: settle timing on a change from A to B
    chanAData = 8'h11; chanBData = 8'h22;
    step(1);
    chk("R11 chan A follow", devDataOut, 8'h11);
    hostSelAlt = 1'b1;
    step(SETTLE + 1);
    chk("R2 old value held", devDataOut, 8'h11);
    step(1);
    chk("R2 new source shown", devDataOut, 8'h22);

    // R1/R11 sweep channel B then channel A
    for (int v = 0; v < 256; v++) begin
      chanBData = 8'(v); chanAData = 8'(255 - v);
      step(1);
      chk("R11 chan B sweep", devDataOut, 8'(v));
    end
    selectSrc(2'b00);
    for (int v = 0; v < 256; v++) begin
      chanAData = 8'(v); chanBData = 8'(v ^ 8'hFF);
      step(1);
      chk("R11 chan A sweep", devDataOut, 8'(v));
    end
    selectSrc(2'b11);
    chk("R1 id code", devDataOut, 8'h55);
    chanAData = 8'h00; chanBData = 8'hFF;
    step(2);
    chk("R1 id code fixed", devDataOut, 8'h55);

    // R3 output enable
    hostReadEn = 1'b0; #1;
    chk("R3 oe low", {7'd0, devDataOe}, 8'h00);
    hostReadEn = 1'b1; #1;
    chk("R3 oe high", {7'd0, devDataOe}, 8'h01);

    // R4/R5/R6 mailbox sweep
    selectSrc(2'b10);
    chk("R10 empty mailbox host view", devDataOut, 8'h00);
    for (int v = 1; v < 256; v++) begin
      logic [7:0] w;
      w = 8'(v) ^ 8'h5A;
      if (w == 8'h00) w = 8'h33;
      locWrEn = 1'b1; locWrData = 8'(v);
      step(1);
      locWrEn = 1'b0;
      chk("R6 local view blank", locRdData, 8'h00);
      step(1);
      chk("R5 host sees local byte", devDataOut, 8'(v));
      hostReadEn = 1'b0; hostDataIn = w; hostStrobe = 1'b1;
      step(1);
      chk("R4 local sees host byte", locRdData, w);
      step(1);
      chk("R5 host view blank", devDataOut, 8'h00);
      hostStrobe = 1'b0; hostReadEn = 1'b1;
    end

    // R7 zero writes
    locWrEn = 1'b1; locWrData = 8'h00;
    step(1);
    locWrEn = 1'b0;
    chk("R7 local zero ignored", locRdData, 8'hFF ^ 8'h5A);
    step(1);
    chk("R7 host view unchanged", devDataOut, 8'h00);
    locWrEn = 1'b1; locWrData = 8'h40;
    step(1);
    locWrEn = 1'b0;
    hostReadEn = 1'b0; hostDataIn = 8'h00; hostStrobe = 1'b1;
    step(1);
    chk("R7 host zero ignored", locRdData, 8'h00);
    step(1);
    chk("R7 host view keeps byte", devDataOut, 8'h40);
    hostStrobe = 1'b0; hostReadEn = 1'b1;
    step(1);

    // R9 ignored strobes
    {hostSelMbx, hostSelAlt} = 2'b00;
    hostReadEn = 1'b0; hostDataIn = 8'h77; hostStrobe = 1'b1;
    step(2);
    chk("R9 strobe off mailbox", locRdData, 8'h00);
    hostStrobe = 1'b0; hostReadEn = 1'b1;
    selectSrc(2'b10);
    hostDataIn = 8'h78; hostStrobe = 1'b1;
    step(2);
    chk("R9 strobe while host reads", locRdData, 8'h00);
    chk("R9 host view intact", devDataOut, 8'h40);
    hostStrobe = 1'b0;
    step(1);
    hostReadEn = 1'b0; hostDataIn = 8'h66; hostStrobe = 1'b1;
    step(1);
    chk("R4 write with strobe", locRdData, 8'h66);
    locWrEn = 1'b1; locWrData = 8'h12;
    step(1);
    locWrEn = 1'b0;
    step(2);
    chk("R9 held strobe writes once", locRdData, 8'h00);
    chk("R5 host sees reply", devDataOut, 8'h12);
    hostStrobe = 1'b0; hostReadEn = 1'b1;
    step(1);

    // R8 collision
    locWrEn = 1'b1; locWrData = 8'h21;
    hostReadEn = 1'b0; hostDataIn = 8'h9C; hostStrobe = 1'b1;
    step(1);
    locWrEn = 1'b0; hostStrobe = 1'b0; hostReadEn = 1'b1;
    chk("R8 local byte first", locRdData, 8'h00);
    step(1);
    chk("R8 host byte lands next", locRdData, 8'h9C);
    chk("R8 host saw local byte", devDataOut, 8'h21);
    step(1);
    chk("R8 host view blank after", devDataOut, 8'h00);

    finishRun();
  end
endmodule